// File: doc/BRIEF.md
# Link control state machine

This block supervises start-up and recovery of one end of a SpaceWire-style serial link. It does not touch the line, the data-strobe coding, the credit counters or the FIFOs. It takes a start policy from three controls, plus one-cycle event strobes from the receiver. From these it decides which characters the transmitter may send and whether the receiver is enabled. It also raises status flags and one-cycle error pulses.

After reset, and after any fault, the link spends a fixed time in an error-reset phase with the receiver off. It then spends a fixed time in an error-wait phase with the receiver listening, and then settles in Ready. There are two ways to start the link. A start request starts it directly. Automatic mode starts it when a NULL arrives. A disable input overrides both and also tears down an active link. In Started the link sends NULLs, and in Connecting it adds FCTs. Run enables all traffic.

Both fixed times, and the handshake timeouts, are derived from a clock-frequency parameter. The error-reset time is 6.4 us and the error-wait and timeout windows are 12.8 us. At the default 125 MHz these are 800 and 1600 cycles.

Top module: `lnk_ctrl_fsm`

## Requirements
- R1: While reset is applied and in the first cycle after it, every output is low.
- R2: Error-reset holds rx_en_o low for exactly SHORT (800 by default) cycles. Error-wait then holds rx_en_o high for LONG (1600) cycles, and the link then enters Ready. With start_req_i held high, Ready lasts one cycle, so rx_en_o is high with no status flag for 1601 cycles.
- R3: With auto_start_i and start_req_i both low, the link stays in Ready indefinitely. A NULL received in Ready is then ignored.
- R4: Ready moves to Started at the next edge when start_req_i is high, or when auto_start_i is high and rx_null_i pulses.
- R5: link_dis_i high keeps the link in Ready. It also forces Started, Connecting or Run to error-reset at the next edge.
- R6: In Started only tx_null_en_o is high among the transmit enables. A NULL moves the link to Connecting. If no NULL arrives, the link returns to error-reset after exactly LONG cycles in Started.
- R7: In Connecting, tx_null_en_o and tx_fct_en_o are high and tx_all_en_o is low. An FCT moves the link to Run. If no FCT arrives, the link returns to error-reset after exactly LONG cycles.
- R8: In Run all three transmit enables and st_run_o are high.
- R9: A disconnect, parity or escape event in Run forces error-reset. The matching err_*_o output pulses high for exactly one cycle, in the first cycle of error-reset.
- R10: A credit error in Connecting or Run forces error-reset and pulses err_cred_o for one cycle.
- R11: In Started, an FCT, N-Char or Time-Code forces error-reset with no error pulse. In Connecting, an N-Char or Time-Code does the same.
- R12: In error-wait or Ready, a disconnect, parity or escape event forces error-reset with no error pulse.
- R13: At most one of st_started_o, st_connecting_o and st_run_o is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| auto_start_i | input | 1 | Start on a received NULL |
| start_req_i | input | 1 | Start as soon as Ready is reached |
| link_dis_i | input | 1 | Disable; overrides starting and tears down an active link |
| rx_null_i | input | 1 | Strobe: NULL received |
| rx_fct_i | input | 1 | Strobe: FCT received |
| rx_nchar_i | input | 1 | Strobe: N-Char received |
| rx_tcode_i | input | 1 | Strobe: Time-Code received |
| rx_disc_i | input | 1 | Strobe: disconnect detected |
| rx_par_i | input | 1 | Strobe: parity error |
| rx_esc_i | input | 1 | Strobe: invalid escape sequence |
| cred_err_i | input | 1 | Strobe: credit error |
| tx_null_en_o | output | 1 | Transmitter may send NULLs |
| tx_fct_en_o | output | 1 | Transmitter may send FCTs |
| tx_all_en_o | output | 1 | Transmitter may send all characters |
| rx_en_o | output | 1 | Receiver enabled |
| st_started_o | output | 1 | Link in Started |
| st_connecting_o | output | 1 | Link in Connecting |
| st_run_o | output | 1 | Link in Run |
| err_disc_o | output | 1 | One-cycle pulse: disconnect in Run |
| err_par_o | output | 1 | One-cycle pulse: parity error in Run |
| err_esc_o | output | 1 | One-cycle pulse: escape error in Run |
| err_cred_o | output | 1 | One-cycle pulse: credit error |

## Verification
Every state except error-wait and Ready has its own combination of enables and status flags. A wrong state therefore shows at the ports in the cycle after the edge that caused it. Error-wait and Ready look the same at the ports. They are told apart by time: with a start request held, the receiver-on, no-status interval must last exactly LONG+1 cycles. A timer that is off by one shows up as a phase that is one cycle too long or too short. A wrongly qualified error pulse shows up as a pulse outside Run, or as a pulse lasting two cycles.

// File: rtl/lnk_ctrl_pkg.sv
package lnk_ctrl_pkg;

  typedef enum logic [2:0] {
    LS_ERR_RESET  = 3'd0,
    LS_ERR_WAIT   = 3'd1,
    LS_READY      = 3'd2,
    LS_STARTED    = 3'd3,
    LS_CONNECTING = 3'd4,
    LS_RUN        = 3'd5
  } lnk_state_e;

  // receiver event strobes, one cycle each
  typedef struct packed {
    logic got_null;
    logic got_fct;
    logic got_nchar;
    logic got_tcode;
    logic err_disc;
    logic err_par;
    logic err_esc;
    logic err_cred;
  } lnk_rx_ev_t;

  // error pulse vector positions
  localparam int EP_DISC = 0;
  localparam int EP_PAR  = 1;
  localparam int EP_ESC  = 2;
  localparam int EP_CRED = 3;
  localparam int EP_N    = 4;

  function automatic int unsigned ns_to_cyc(input longint unsigned hz,
                                            input longint unsigned ns);
    longint unsigned c;
    c = (hz * ns) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return 32'(c);
  endfunction

endpackage

// File: rtl/lnk_ctrl_rstsync.sv
module lnk_ctrl_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sh_q <= '0;
    else              sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/lnk_ctrl_timer.sv
module lnk_ctrl_timer #(
  parameter int unsigned SHORT_CYC = 800,
  parameter int unsigned LONG_CYC  = 1600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic short_done,
  output logic long_done
);
  localparam int CW = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = restart || (cnt_q != LONG_LAST);

  always_comb begin
    if (restart) cnt_d = '0;
    else         cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign short_done = (cnt_q >= SHORT_LAST);
  assign long_done  = (cnt_q == LONG_LAST);

  // R2: counter saturates at the long window and never runs past it
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LONG_LAST);
endmodule

// File: rtl/lnk_ctrl_core.sv
module lnk_ctrl_core
  import lnk_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             autostart,
  input  logic             linkstart,
  input  logic             linkdis,
  input  lnk_rx_ev_t       ev,
  input  logic             short_done,
  input  logic             long_done,
  output logic             restart,
  output lnk_state_e       state_q,
  output logic [EP_N-1:0]  err_q
);
  lnk_state_e      state_d;
  logic            line_err;
  logic            data_like;
  logic [EP_N-1:0] err_src;
  logic [EP_N-1:0] err_qual;
  logic            in_run, in_conn;

  assign line_err  = ev.err_disc | ev.err_par | ev.err_esc;
  assign data_like = ev.got_nchar | ev.got_tcode;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LS_ERR_RESET: begin
        if (short_done) state_d = LS_ERR_WAIT;
      end
      LS_ERR_WAIT: begin
        if (line_err || data_like || ev.got_fct) state_d = LS_ERR_RESET;
        else if (long_done)                      state_d = LS_READY;
      end
      LS_READY: begin
        if (line_err || data_like || ev.got_fct) state_d = LS_ERR_RESET;
        else if (!linkdis && (linkstart || (autostart && ev.got_null)))
          state_d = LS_STARTED;
      end
      LS_STARTED: begin
        if (linkdis || line_err || data_like || ev.got_fct || long_done)
          state_d = LS_ERR_RESET;
        else if (ev.got_null) state_d = LS_CONNECTING;
      end
      LS_CONNECTING: begin
        if (linkdis || line_err || data_like || ev.err_cred || long_done)
          state_d = LS_ERR_RESET;
        else if (ev.got_fct) state_d = LS_RUN;
      end
      LS_RUN: begin
        if (linkdis || line_err || ev.err_cred) state_d = LS_ERR_RESET;
      end
      default: state_d = LS_ERR_RESET;
    endcase
  end

  assign restart = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LS_ERR_RESET;
    else        state_q <= state_d;
  end

  // error pulses: one register per source, each with its own state qualifier
  assign in_run  = (state_q == LS_RUN);
  assign in_conn = (state_q == LS_CONNECTING);

  assign err_src[EP_DISC] = ev.err_disc;
  assign err_src[EP_PAR]  = ev.err_par;
  assign err_src[EP_ESC]  = ev.err_esc;
  assign err_src[EP_CRED] = ev.err_cred;

  genvar gi;
  generate
    for (gi = 0; gi < EP_N; gi++) begin : g_errp
      if (gi == EP_CRED) begin : g_cred
        assign err_qual[gi] = in_run | in_conn;
      end else begin : g_line
        assign err_qual[gi] = in_run;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q[gi] <= 1'b0;
        else        err_q[gi] <= err_src[gi] & err_qual[gi];
      end
    end
  endgenerate

  // R4: Started is only ever entered from Ready on a start condition
  p_start_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LS_STARTED && $past(state_q) != LS_STARTED) |->
      ($past(state_q) == LS_READY && $past(linkstart || (autostart && ev.got_null))));

  // R5: disable tears down any active state at the next edge
  p_linkdis_kills_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (linkdis && (state_q == LS_STARTED || state_q == LS_CONNECTING || state_q == LS_RUN))
      |=> state_q == LS_ERR_RESET);

  // R7: Run is entered only from Connecting on a received FCT
  p_run_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == LS_RUN) |-> ($past(state_q) == LS_CONNECTING && $past(ev.got_fct)));

  // R9: an error pulse coincides with the first cycle of error-reset
  p_pulse_in_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_q) |-> state_q == LS_ERR_RESET);

  // R9: error pulses last a single cycle
  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_q) |=> err_q == '0);
endmodule

// File: rtl/lnk_ctrl_fsm.sv
module lnk_ctrl_fsm
  import lnk_ctrl_pkg::*;
#(
  parameter longint unsigned CLK_HZ   = 125_000_000,
  parameter longint unsigned SHORT_NS = 6_400,
  parameter longint unsigned LONG_NS  = 12_800,
  parameter int              SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic auto_start_i,
  input  logic start_req_i,
  input  logic link_dis_i,
  input  logic rx_null_i,
  input  logic rx_fct_i,
  input  logic rx_nchar_i,
  input  logic rx_tcode_i,
  input  logic rx_disc_i,
  input  logic rx_par_i,
  input  logic rx_esc_i,
  input  logic cred_err_i,
  output logic tx_null_en_o,
  output logic tx_fct_en_o,
  output logic tx_all_en_o,
  output logic rx_en_o,
  output logic st_started_o,
  output logic st_connecting_o,
  output logic st_run_o,
  output logic err_disc_o,
  output logic err_par_o,
  output logic err_esc_o,
  output logic err_cred_o
);
  localparam int unsigned SHORT_CYC = ns_to_cyc(CLK_HZ, SHORT_NS);
  localparam int unsigned LONG_CYC  = ns_to_cyc(CLK_HZ, LONG_NS);

  logic            rst_n;
  logic            restart, short_done, long_done;
  lnk_state_e      state;
  lnk_rx_ev_t      ev;
  logic [EP_N-1:0] err_p;

  assign ev = '{got_null:  rx_null_i,  got_fct:  rx_fct_i,
                got_nchar: rx_nchar_i, got_tcode: rx_tcode_i,
                err_disc:  rx_disc_i,  err_par:  rx_par_i,
                err_esc:   rx_esc_i,   err_cred: cred_err_i};

  lnk_ctrl_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk_i), .rst_n_async(rst_ni), .rst_n_sync(rst_n));

  lnk_ctrl_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_tmr (
    .clk(clk_i), .rst_n(rst_n), .restart(restart),
    .short_done(short_done), .long_done(long_done));

  lnk_ctrl_core u_core (
    .clk(clk_i), .rst_n(rst_n), .autostart(auto_start_i),
    .linkstart(start_req_i), .linkdis(link_dis_i), .ev(ev),
    .short_done(short_done), .long_done(long_done),
    .restart(restart), .state_q(state), .err_q(err_p));

  assign st_started_o    = (state == LS_STARTED);
  assign st_connecting_o = (state == LS_CONNECTING);
  assign st_run_o        = (state == LS_RUN);
  assign tx_null_en_o    = st_started_o | st_connecting_o | st_run_o;
  assign tx_fct_en_o     = st_connecting_o | st_run_o;
  assign tx_all_en_o     = st_run_o;
  assign rx_en_o         = (state != LS_ERR_RESET);

  assign err_disc_o = err_p[EP_DISC];
  assign err_par_o  = err_p[EP_PAR];
  assign err_esc_o  = err_p[EP_ESC];
  assign err_cred_o = err_p[EP_CRED];

  // R13: status flags never overlap
  p_status_onehot_r13: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0({st_started_o, st_connecting_o, st_run_o}));
endmodule

// File: tb/lnk_ctrl_fsm_test.sv
module lnk_ctrl_fsm_test;
  localparam int SHORT = 800;
  localparam int LONG  = 1600;

  logic clk = 1'b0;
  logic rst_n;
  logic autost, lstart, ldis;
  logic [7:0] ev; // 0 null,1 fct,2 nchar,3 tcode,4 disc,5 par,6 esc,7 cred
  logic tx_null, tx_fct, tx_all, rx_en, s_st, s_co, s_run;
  logic e_disc, e_par, e_esc, e_cred;
  int total = 0, bad = 0;
  bit overlap = 0;

  always #4 clk = ~clk;

  lnk_ctrl_fsm uut (
    .clk_i(clk), .rst_ni(rst_n), .auto_start_i(autost), .start_req_i(lstart),
    .link_dis_i(ldis), .rx_null_i(ev[0]), .rx_fct_i(ev[1]), .rx_nchar_i(ev[2]),
    .rx_tcode_i(ev[3]), .rx_disc_i(ev[4]), .rx_par_i(ev[5]), .rx_esc_i(ev[6]),
    .cred_err_i(ev[7]), .tx_null_en_o(tx_null), .tx_fct_en_o(tx_fct),
    .tx_all_en_o(tx_all), .rx_en_o(rx_en), .st_started_o(s_st),
    .st_connecting_o(s_co), .st_run_o(s_run), .err_disc_o(e_disc),
    .err_par_o(e_par), .err_esc_o(e_esc), .err_cred_o(e_cred));

  always @(negedge clk) if (rst_n && (32'(s_st) + 32'(s_co) + 32'(s_run) > 1)) overlap = 1;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic strobe(input int idx);
    ev[idx] = 1'b1; tick(); ev[idx] = 1'b0;
  endtask

  function automatic int outs();
    return {tx_null, tx_fct, tx_all, rx_en, s_st, s_co, s_run,
            e_disc, e_par, e_esc, e_cred};
  endfunction

  function automatic int errs();
    return {e_disc, e_par, e_esc, e_cred};
  endfunction

  task automatic wait_for(input string req, input bit want_started);
    int n = 0;
    while ((want_started ? s_st : rx_en) !== 1'b1 && n < 6000) begin tick(); n++; end
    if (n >= 6000) check(req, 0, 1);
  endtask

  task automatic to_run();
    ldis = 0; lstart = 1;
    wait_for("R4", 1);
    strobe(0); strobe(1);
  endtask

  task automatic t_reset();
    rst_n = 0; autost = 0; lstart = 0; ldis = 0; ev = '0;
    repeat (3) tick();
    check("R1 outputs in reset", outs(), 0);
    rst_n = 1; tick();
    check("R1 outputs after release", outs(), 0);
  endtask

  task automatic t_ready_hold();
    wait_for("R3", 0);
    repeat (2000) tick();
    check("R3 no start without controls", s_st, 0);
    strobe(0);
    check("R3 NULL ignored w/o autostart", {s_st, rx_en}, 1);
  endtask

  task automatic t_autostart();
    autost = 1; strobe(0);
    check("R4 autostart on NULL", s_st, 1);
    check("R6 started enables", {tx_null, tx_fct, tx_all}, 3'b100);
    strobe(0);
    check("R7 connecting enables", {s_co, tx_null, tx_fct, tx_all}, 4'b1110);
    strobe(1);
    check("R8 run enables", {s_run, tx_null, tx_fct, tx_all}, 4'b1111);
  endtask

  task automatic t_par_timing();
    int low, hi;
    lstart = 1;
    strobe(5);
    check("R9 parity pulse", {e_par, s_run, rx_en}, 3'b100);
    low = 1; tick();
    check("R9 parity pulse ends", e_par, 0);
    while (!rx_en && low < 5000) begin low++; tick(); end
    check("R2 error-reset length", low, SHORT);
    hi = 0;
    while (rx_en && !s_st && hi < 5000) begin hi++; tick(); end
    check("R2 error-wait plus ready length", hi, LONG + 1);
  endtask

  task automatic t_linkdis();
    to_run();
    ldis = 1; tick();
    check("R5 disable tears down Run", {s_run, rx_en}, 0);
    repeat (3000) tick();
    check("R5 disable holds Ready", {s_st, rx_en}, 2'b01);
    ldis = 0; tick();
    check("R5 start after disable drops", s_st, 1);
    ldis = 1; tick();
    check("R5 disable tears down Started", {s_st, rx_en}, 0);
    ldis = 0;
  endtask

  task automatic t_start_timeout();
    int n = 0;
    autost = 0; lstart = 1;
    wait_for("R6", 1);
    while (s_st && n < 5000) begin n++; tick(); end
    check("R6 started timeout length", n, LONG);
    check("R6 timeout to error-reset", rx_en, 0);
  endtask

  task automatic t_conn_timeout();
    int n = 0;
    wait_for("R7", 1);
    strobe(0);
    while (s_co && n < 5000) begin n++; tick(); end
    check("R7 connecting timeout length", n, LONG);
    check("R7 timeout to error-reset", rx_en, 0);
  endtask

  task automatic t_premature();
    wait_for("R11", 1); strobe(2);
    check("R11 N-Char in Started", {s_st, rx_en}, 0);
    check("R11 no pulse", errs(), 0);
    wait_for("R11", 1); strobe(1);
    check("R11 FCT in Started", {s_st, s_co, rx_en}, 0);
    wait_for("R11", 1); strobe(0); strobe(3);
    check("R11 Time-Code in Connecting", {s_co, rx_en}, 0);
    check("R11 no pulse in Connecting", errs(), 0);
  endtask

  task automatic t_cred();
    wait_for("R10", 1); strobe(0); strobe(7);
    check("R10 credit in Connecting", {e_cred, s_co, rx_en}, 3'b100);
    tick(); check("R10 credit pulse ends", e_cred, 0);
    to_run(); strobe(7);
    check("R10 credit in Run", {e_cred, s_run, rx_en}, 3'b100);
  endtask

  task automatic t_disc_esc();
    to_run(); strobe(4);
    check("R9 disconnect in Run", {e_disc, e_par, e_esc, rx_en}, 4'b1000);
    to_run(); strobe(6);
    check("R9 escape in Run", {e_disc, e_par, e_esc, rx_en}, 4'b0010);
    tick(); check("R9 escape pulse ends", e_esc, 0);
  endtask

  task automatic t_wait_err();
    lstart = 0;
    wait_for("R12", 0);
    strobe(4);
    check("R12 disconnect in error-wait", {rx_en, e_disc}, 0);
    wait_for("R12", 0);
    repeat (2000) tick();
    strobe(5);
    check("R12 parity in Ready", {rx_en, e_par}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_ready_hold();
    t_autostart();
    t_par_timing();
    t_linkdis();
    t_start_timeout();
    t_conn_timeout();
    t_premature();
    t_cred();
    t_disc_esc();
    t_wait_err();
    check("R13 status flags overlap", 32'(overlap), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule